// File: doc/BRIEF.md
# Quarter-Duty Multiplexed LCD Waveform Generator

This block produces the drive-level codes for a 1/4-duty multiplexed liquid-crystal panel with four common lines and up to 66 segment lines. It is clocked by the system clock and advanced by a single-cycle oscillator enable. A frame is eight phases long and each phase lasts a fixed number of enabled ticks. Each of the four commons is selected once in the first half of the frame and once more, with reversed polarity, in the second half. This keeps the average voltage across every pixel at zero.

Two inputs come from the host. The first is a latched display image of four bits per segment. The second is a set of mode inputs: a bias select, a segment blanking control, a power-save control and an active-low display inhibit. Every output is a 3-bit level code that an external analog stage turns into ground, one third, one half, two thirds or the full panel supply. The bias divider, the output buffers and the oscillator are outside this block.

Top module: `lcdq_wavegen`

## Requirements
- R1: Every output is a 3-bit level code: 0 ground, 1 one third, 2 one half, 3 two thirds, 4 full supply. No other code appears.
- R2: The frame has 8 phases, and the phase advances after every PHASE_TICKS ticks of osc_en, so one frame is 8*PHASE_TICKS ticks. In phases 0..3, common j (com_lvl bits [3j+2:3j]) is selected in phase j and driven to code 4. In phases 4..7, common j is selected in phase j+4 and driven to code 0.
- R3: An unselected common is driven to code 2 under 1/2 bias. Under 1/3 bias it is driven to code 1 in phases 0..3 and to code 3 in phases 4..7.
- R4: Segment k (seg_lvl bits [3k+2:3k]) takes image bit disp_img[4k+j] while common j is selected. A lit segment (bit 1) is driven opposite to the selected common: code 0 in phases 0..3 and code 4 in phases 4..7.
- R5: An unlit segment is driven to the same code as the selected common under 1/2 bias. Under 1/3 bias it is driven to code 3 in phases 0..3 and to code 1 in phases 4..7.
- R6: bias_half=1 selects 1/2 bias and bias_half=0 selects 1/3 bias. A change of bias_half takes effect on the outputs in the same cycle, without disturbing the phase timing.
- R7: While seg_blank=1, every segment shows its unlit code whatever the image, and the commons keep their normal sequence.
- R8: While pwr_save=1, every common and segment output is code 0 and the phase timing is held at its start. After release, phase 0 runs for a full PHASE_TICKS ticks.
- R9: While inh_n=0, every output is code 0 and the phase timing is held at its start, whatever pwr_save, seg_blank and the image are. After release, phase 0 runs for a full PHASE_TICKS ticks.
- R10: While osc_en is low, the phase does not advance.
- R11: After reset the block is in phase 0 with a fresh tick count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator tick, one clock wide |
| disp_img | input | 4*NUM_SEG | Display image, bit 4k+j = segment k at common j |
| bias_half | input | 1 | 1 = 1/2 bias, 0 = 1/3 bias |
| seg_blank | input | 1 | 1 = all segments show the unlit code |
| pwr_save | input | 1 | 1 = outputs at ground, timing held |
| inh_n | input | 1 | 0 = display forced off, timing held |
| com_lvl | output | 12 | Level codes of the four commons, 3 bits each |
| seg_lvl | output | 3*NUM_SEG | Level codes of the segments, 3 bits each |

## Verification
The bound assertions check the following on every cycle:
- the forced-ground behaviour of inhibit and power-save;
- that exactly one common sits at an extreme code while the block is running;
- that the common and segment codes legal for the selected bias are the only ones that appear;
- that blanking under 1/3 bias keeps every segment off the extreme codes;
- that the commons are stable without an oscillator tick;
- that the restart lands in phase 0.

Some behaviours only the bench's scenarios can show, because the bench compares every output with a behavioural model each clock. These are the exact length of each phase, the pixel-to-bit mapping of every segment, the per-half polarity of lit and unlit segments, and the full length of phase 0 after power-save or inhibit is released.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;
   localparam int LVL_W   = 3;
   localparam int NUM_COM = 4;
   localparam int NUM_PH  = 2 * NUM_COM;
   localparam int PH_W    = $clog2(NUM_PH);
   localparam int SEL_W   = $clog2(NUM_COM);

   typedef enum logic [LVL_W-1:0] {
      LV_GND   = 3'd0,
      LV_THIRD = 3'd1,
      LV_HALF  = 3'd2,
      LV_TWO3  = 3'd3,
      LV_FULL  = 3'd4
   } lvl_e;
endpackage

// File: rtl/lcdq_timebase.sv
module lcdq_timebase import lcdq_pkg::*; #(
   parameter int PHASE_TICKS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             osc_en,
   output logic [SEL_W-1:0] com_sel,
   output logic             pol_pos
);
   localparam int TICK_W = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
   localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(PHASE_TICKS - 1);

   logic [TICK_W-1:0] tick_q;
   logic [PH_W-1:0]   phase_q;

   // the timing restarts from the beginning whenever the drive is off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q  <= '0;
         phase_q <= '0;
      end else if (!run) begin
         tick_q  <= '0;
         phase_q <= '0;
      end else if (osc_en) begin
         if (tick_q == TICK_LAST) begin
            tick_q  <= '0;
            phase_q <= phase_q + 1'b1;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   assign com_sel = phase_q[SEL_W-1:0];
   assign pol_pos = ~phase_q[PH_W-1];
endmodule

// File: rtl/lcdq_com_drive.sv
module lcdq_com_drive import lcdq_pkg::*; (
   input  logic                     active,
   input  logic                     bias_half,
   input  logic [SEL_W-1:0]         com_sel,
   input  logic                     pol_pos,
   output logic [NUM_COM*LVL_W-1:0] com_lvl
);
   for (genvar j = 0; j < NUM_COM; j++) begin : g_com
      lvl_e lv;
      always_comb begin
         if (!active)
            lv = LV_GND;
         else if (com_sel == SEL_W'(j))
            lv = pol_pos ? LV_FULL : LV_GND;
         else if (bias_half)
            lv = LV_HALF;
         else
            lv = pol_pos ? LV_THIRD : LV_TWO3;
      end
      assign com_lvl[j*LVL_W +: LVL_W] = lv;
   end
endmodule

// File: rtl/lcdq_seg_drive.sv
module lcdq_seg_drive import lcdq_pkg::*; (
   input  logic               active,
   input  logic               bias_half,
   input  logic               blank,
   input  logic [NUM_COM-1:0] pix,
   input  logic [SEL_W-1:0]   com_sel,
   input  logic               pol_pos,
   output logic [LVL_W-1:0]   lvl
);
   logic lit;
   lvl_e lv;

   assign lit = pix[com_sel] & ~blank;

   always_comb begin
      if (!active)
         lv = LV_GND;
      else if (lit)
         lv = pol_pos ? LV_GND : LV_FULL;
      else if (bias_half)
         lv = pol_pos ? LV_FULL : LV_GND;
      else
         lv = pol_pos ? LV_TWO3 : LV_THIRD;
   end

   assign lvl = lv;
endmodule

// File: rtl/lcdq_wavegen.sv
module lcdq_wavegen import lcdq_pkg::*; #(
   parameter int NUM_SEG     = 66,
   parameter int PHASE_TICKS = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     osc_en,
   input  logic [NUM_SEG*4-1:0]     disp_img,
   input  logic                     bias_half,
   input  logic                     seg_blank,
   input  logic                     pwr_save,
   input  logic                     inh_n,
   output logic [NUM_COM*LVL_W-1:0] com_lvl,
   output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);
   initial begin
      assert (NUM_SEG >= 1) else $error("NUM_SEG must be at least 1");
      assert (PHASE_TICKS >= 2) else $error("PHASE_TICKS must be at least 2");
   end

   logic             active;
   logic [SEL_W-1:0] com_sel;
   logic             pol_pos;

   assign active = inh_n & ~pwr_save;

   lcdq_timebase #(.PHASE_TICKS(PHASE_TICKS)) i_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (active),
      .osc_en  (osc_en),
      .com_sel (com_sel),
      .pol_pos (pol_pos)
   );

   lcdq_com_drive i_com (
      .active    (active),
      .bias_half (bias_half),
      .com_sel   (com_sel),
      .pol_pos   (pol_pos),
      .com_lvl   (com_lvl)
   );

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
      lcdq_seg_drive i_seg (
         .active    (active),
         .bias_half (bias_half),
         .blank     (seg_blank),
         .pix       (disp_img[k*NUM_COM +: NUM_COM]),
         .com_sel   (com_sel),
         .pol_pos   (pol_pos),
         .lvl       (seg_lvl[k*LVL_W +: LVL_W])
      );
   end
endmodule

// File: rtl/lcdq_wavegen_chk.sv
module lcdq_wavegen_chk import lcdq_pkg::*; #(
   parameter int NUM_SEG = 66
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     osc_en,
   input logic                     bias_half,
   input logic                     seg_blank,
   input logic                     pwr_save,
   input logic                     inh_n,
   input logic [NUM_COM*LVL_W-1:0] com_lvl,
   input logic [NUM_SEG*LVL_W-1:0] seg_lvl
);
   logic       running;
   logic [2:0] n_extreme;
   logic       com_third_used, com_half_used, com_bad_code;
   logic       seg_mid_used, seg_bad_code, seg_extreme_used;

   assign running = inh_n & ~pwr_save;

   always_comb begin
      n_extreme      = '0;
      com_third_used = 1'b0;
      com_half_used  = 1'b0;
      com_bad_code   = 1'b0;
      for (int j = 0; j < NUM_COM; j++) begin
         if (com_lvl[j*LVL_W +: LVL_W] == LV_FULL || com_lvl[j*LVL_W +: LVL_W] == LV_GND)
            n_extreme = n_extreme + 3'd1;
         if (com_lvl[j*LVL_W +: LVL_W] == LV_THIRD || com_lvl[j*LVL_W +: LVL_W] == LV_TWO3)
            com_third_used = 1'b1;
         if (com_lvl[j*LVL_W +: LVL_W] == LV_HALF)
            com_half_used = 1'b1;
         if (com_lvl[j*LVL_W +: LVL_W] > LV_FULL)
            com_bad_code = 1'b1;
      end
   end

   always_comb begin
      seg_mid_used     = 1'b0;
      seg_bad_code     = 1'b0;
      seg_extreme_used = 1'b0;
      for (int k = 0; k < NUM_SEG; k++) begin
         if (seg_lvl[k*LVL_W +: LVL_W] != LV_GND && seg_lvl[k*LVL_W +: LVL_W] != LV_FULL)
            seg_mid_used = 1'b1;
         else
            seg_extreme_used = 1'b1;
         if (seg_lvl[k*LVL_W +: LVL_W] == LV_HALF || seg_lvl[k*LVL_W +: LVL_W] > LV_FULL)
            seg_bad_code = 1'b1;
      end
   end

   assert_codes_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !com_bad_code && !seg_bad_code);

   assert_one_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (n_extreme == 3'd1));

   // R3: the unselected commons use only the levels of the chosen bias
   assert_com_bias_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (bias_half ? !com_third_used : !com_half_used));

   // R5 and R6: under 1/2 bias the segments swing only between the rails
   assert_half_bias_seg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && bias_half) |-> !seg_mid_used);

   assert_blank_no_lit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && seg_blank && !bias_half) |-> !seg_extreme_used);

   assert_forced_ground_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!inh_n || pwr_save) |-> (com_lvl == '0 && seg_lvl == '0));

   assert_restart_phase0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (com_lvl[LVL_W-1:0] == LV_FULL));

   assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !$past(osc_en) && $stable(bias_half)) |-> $stable(com_lvl));
endmodule

bind lcdq_wavegen lcdq_wavegen_chk #(.NUM_SEG(NUM_SEG)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .osc_en    (osc_en),
   .bias_half (bias_half),
   .seg_blank (seg_blank),
   .pwr_save  (pwr_save),
   .inh_n     (inh_n),
   .com_lvl   (com_lvl),
   .seg_lvl   (seg_lvl)
);

// File: tb/test_lcdq_wavegen.sv
module test_lcdq_wavegen;
   localparam int CLK_PERIOD = 10;
   localparam int NSEG       = 66;
   localparam int PT         = 64;
   localparam int MAX_CYC    = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              osc_en = 1'b0;
   logic [NSEG*4-1:0] disp_img = '0;
   logic              bias_half = 1'b0;
   logic              seg_blank = 1'b0;
   logic              pwr_save = 1'b0;
   logic              inh_n = 1'b1;
   logic [11:0]       com_lvl;
   logic [NSEG*3-1:0] seg_lvl;

   int n_checks = 0;
   int n_errors = 0;
   int cyc      = 0;
   int osc_div  = 1;
   int osc_cnt  = 0;
   bit done     = 0;

   // behavioural reference state
   int m_tick  = 0;
   int m_phase = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcdq_wavegen #(.NUM_SEG(NSEG), .PHASE_TICKS(PT)) i_lcdq_wavegen (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .disp_img(disp_img),
      .bias_half(bias_half), .seg_blank(seg_blank), .pwr_save(pwr_save),
      .inh_n(inh_n), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n || !inh_n || pwr_save) begin
         m_tick  = 0;
         m_phase = 0;
      end else if (osc_en) begin
         m_tick = m_tick + 1;
         if (m_tick == PT) begin
            m_tick  = 0;
            m_phase = (m_phase + 1) % 8;
         end
      end
   end

   function automatic int exp_com(int j);
      bit on  = inh_n && !pwr_save;
      bit pos = (m_phase < 4);
      if (!on) return 0;
      if (j == m_phase % 4) return pos ? 4 : 0;
      if (bias_half) return 2;
      return pos ? 1 : 3;
   endfunction

   function automatic int exp_seg(int k);
      bit on  = inh_n && !pwr_save;
      bit pos = (m_phase < 4);
      bit lit = disp_img[4*k + m_phase % 4] && !seg_blank;
      if (!on) return 0;
      if (lit) return pos ? 0 : 4;
      if (bias_half) return pos ? 4 : 0;
      return pos ? 3 : 1;
   endfunction

   task automatic compare_all();
      string tag;
      bit bad = 0;
      if (!inh_n) tag = "R9";
      else if (pwr_save) tag = "R8";
      else if (seg_blank) tag = "R7";
      else tag = "R2/R3";
      n_checks++;
      for (int j = 0; j < 4; j++)
         if (!bad && int'(com_lvl[3*j +: 3]) != exp_com(j)) begin
            bad = 1;
            $display("FAIL %s com%0d phase %0d: got %0d expected %0d",
                     tag, j, m_phase, com_lvl[3*j +: 3], exp_com(j));
         end
      if (inh_n && !pwr_save && !seg_blank) tag = "R4/R5";
      for (int k = 0; k < NSEG; k++)
         if (!bad && int'(seg_lvl[3*k +: 3]) != exp_seg(k)) begin
            bad = 1;
            $display("FAIL %s seg%0d phase %0d: got %0d expected %0d",
                     tag, k, m_phase, seg_lvl[3*k +: 3], exp_seg(k));
         end
      if (bad) n_errors++;
   endtask

   // one clock: compare at the falling edge, then drive the next osc tick
   task automatic run_cycles(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
         osc_cnt++;
         osc_en = (osc_div != 0) && (osc_cnt % ((osc_div != 0) ? osc_div : 1) == 0);
      end
   endtask

   task automatic check_val(string req, int got, int expv);
      n_checks++;
      if (got != expv) begin
         n_errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, expv);
      end
   endtask

   function automatic logic [NSEG*4-1:0] make_img(int kind);
      logic [NSEG*4-1:0] v;
      for (int i = 0; i < NSEG*4; i++)
         case (kind)
            0: v[i] = 1'b1;
            1: v[i] = ((i * 7 + 3) % 5) < 2;
            2: v[i] = (i % 3) == 0;
            default: v[i] = 1'b0;
         endcase
      return v;
   endfunction

   initial begin : watchdog
      repeat (MAX_CYC) @(posedge clk);
      if (!done) begin
         done = 1;
         n_errors++;
         $display("FAIL watchdog: got %0d cycles expected fewer", MAX_CYC);
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [11:0] held;
      disp_img = make_img(1);
      repeat (3) @(negedge clk);
      // R11: phase 0 while in reset and right after it
      check_val("R11 com0 in reset", int'(com_lvl[2:0]), 4);
      check_val("R11 com1 in reset", int'(com_lvl[5:3]), 1);
      rst_n = 1'b1;
      run_cycles(1);
      check_val("R11 com0 after reset", int'(com_lvl[2:0]), 4);

      // R2 R3 R4 R5: 1/3 bias, tick every clock, two frames
      run_cycles(2 * 8 * PT + 5);

      // R6: 1/2 bias, sparse ticks, another image
      bias_half = 1'b1;
      disp_img  = make_img(2);
      osc_div   = 3;
      run_cycles(8 * PT * 3 + 7);

      // R6: bias flips mid-phase; same cycle effect on an unselected common
      osc_div = 1;
      run_cycles(40);
      bias_half = 1'b0;
      #1;
      check_val("R6 bias switch immediate", (int'(com_lvl[2:0]) == 2 || int'(com_lvl[5:3]) == 2) ? 1 : 0, 0);
      run_cycles(300);

      // R7: blanking with all pixels lit, both biases
      disp_img  = make_img(0);
      seg_blank = 1'b1;
      run_cycles(8 * PT + 11);
      bias_half = 1'b1;
      run_cycles(300);
      seg_blank = 1'b0;
      run_cycles(200);

      // R8: power save mid-frame, then full phase 0 after release
      pwr_save = 1'b1;
      run_cycles(100);
      check_val("R8 seg0 ground", int'(seg_lvl[2:0]), 0);
      pwr_save = 1'b0;
      run_cycles(PT + 5);

      // R9: inhibit overrides blanking and power save
      disp_img  = make_img(3);
      seg_blank = 1'b1;
      inh_n     = 1'b0;
      run_cycles(50);
      pwr_save = 1'b1;
      run_cycles(30);
      check_val("R9 com all ground", int'(com_lvl), 0);
      pwr_save  = 1'b0;
      seg_blank = 1'b0;
      inh_n     = 1'b1;
      bias_half = 1'b0;
      disp_img  = make_img(1);
      run_cycles(8 * PT + 3);

      // R10: no osc ticks means frozen phase
      osc_div = 0;
      run_cycles(2);
      held = com_lvl;
      run_cycles(200);
      check_val("R10 commons frozen", (com_lvl == held) ? 1 : 0, 1);
      osc_div = 1;
      run_cycles(8 * PT);

      // R1: the codes seen on the ports stay within 0..4
      check_val("R1 code range com3", (int'(com_lvl[11:9]) <= 4) ? 1 : 0, 1);

      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule